// File: doc/BRIEF.md
# Prioritized Multi-Counter Memory Addresser

This block owns the address and strobe pins of one byte-wide external SRAM that several internal functions share. Five sources each keep their own address counter: converter sample traffic, record/playback stream traffic, error-correction traffic, subcode traffic, and a clear/refresh source. A source asks for the memory by holding its request bit. On every memory slot, marked by a slot-clock enable, a fixed-priority arbiter grants one source. The block then drives that source's counter onto the 15-bit address bus together with active-low chip-enable, write-enable and output-enable. The granted counter then steps on by one.

Any counter can be preset through a load strobe. A clear command turns the lowest-priority source into a sweep that writes zero to every location in turn. The sweep yields to all other traffic. It raises a done flag once the last location has been written. Because only one source holds the bus in any slot, accesses from different functions never collide.

Top module: `mem_addr_arb`

## Requirements
- R1: While rst_ni is low and after its release, gnt_o is 0, addr_o is 0, ce_no, we_no and oe_no are 1, and zero_fill_o and clear_done_o are 0.
- R2: Outputs change only at a rising clock edge with slot_en_i high. The outputs sampled at that edge (grant, address, strobes) are held for the whole slot, up to the next such edge. A grant therefore lasts exactly one slot.
- R3: Priority by source index is fixed, index 0 highest: 0 converter, 1 stream, 2 error correction, 3 subcode, 4 clear/refresh. The lowest requesting index is granted.
- R4: At most one gnt_o bit is high. A bit k is high only if source k requested at the slot edge (for k = 4, a running clear also counts as a request). With no request, gnt_o is 0.
- R5: ce_no is low exactly in a granted slot. we_no is low in a granted slot whose wr_i bit was 1 (write), and oe_no is low in a granted slot whose wr_i bit was 0 (read). we_no and oe_no are never low together.
- R6: A granted counter advances by one after its access. Counters that are not granted keep their value.
- R7: Counters wrap from 32767 to 0.
- R8: load_i[k] presets counter k from load_addr_i bits [k*15 +: 15]. If source k is granted at the same edge, that access uses the loaded value and the counter then holds the loaded value plus one.
- R9: A pulse on clear_start_i resets source 4's counter to 0 and starts a clear. The clear then requests source 4 in every slot as a write, with zero_fill_o high in those slots. clear_done_o rises in the slot that presents address 32767 and stays high. After that slot the clear stops requesting.
- R10: During a clear, any request from sources 0 to 3 is granted ahead of the clear, and the clear address does not advance in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_en_i | input | 1 | Slot-clock enable; marks the edge that opens a memory slot |
| req_i | input | 5 | Request per source, index 0 highest priority |
| wr_i | input | 5 | Per source: 1 write, 0 read |
| load_i | input | 5 | Preset strobe per counter |
| load_addr_i | input | 75 | Preset values, source k in bits [k*15 +: 15] |
| clear_start_i | input | 1 | Starts a zero-fill sweep |
| gnt_o | output | 5 | One-hot grant for the current slot |
| addr_o | output | 15 | SRAM address |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| zero_fill_o | output | 1 | Current slot is a clear write of zero |
| clear_done_o | output | 1 | Clear sweep finished |

## Verification
Every result is registered on the slot edge. The grant, address, strobes and zero-fill flag of a slot are therefore due one register after the rising edge where slot_en_i is high. The bench drives inputs on the falling edge, lets one rising edge open the slot, and samples on the next falling edge. It then runs a cycle with no slot enable to confirm that the values hold. Loads take effect at the next rising edge, so a load issued together with a grant shows up in that same slot's address. clear_done_o is due in the same sampled cycle as address 32767. The sweep is compared slot by slot against an independently counted address.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned NUM_SRC = 5;
endpackage

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          zero_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] cnt_q;

  // load bypasses into the current access
  assign cur_o = load_i ? load_val_i : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else             cnt_q <= cur_o + AW'(adv_i);
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_addr_arb.sv
module mem_addr_arb
  import mem_arb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned N  = NUM_SRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_en_i,
  input  logic [N-1:0]    req_i,
  input  logic [N-1:0]    wr_i,
  input  logic [N-1:0]    load_i,
  input  logic [N*AW-1:0] load_addr_i,
  input  logic            clear_start_i,
  output logic [N-1:0]    gnt_o,
  output logic [AW-1:0]   addr_o,
  output logic            ce_no,
  output logic            we_no,
  output logic            oe_no,
  output logic            zero_fill_o,
  output logic            clear_done_o
);
  localparam int unsigned CLR = N - 1;

  logic          clearing_q, done_q;
  logic [N-1:0]  req_eff, wr_eff, arb_gnt, pick;
  logic [AW-1:0] cur [N];
  logic [AW-1:0] sel_addr;
  logic          sel_wr, last_hit;

  logic [N-1:0]  gnt_q;
  logic [AW-1:0] addr_q;
  logic          act_q, wr_q, zero_q;

  always_comb begin
    req_eff      = req_i;
    wr_eff       = wr_i;
    req_eff[CLR] = (req_i[CLR] | clearing_q) & ~clear_start_i;
    wr_eff[CLR]  = wr_i[CLR] | clearing_q;
  end

  prio_arbiter #(.N(N)) u_arb (
    .req_i (req_eff),
    .gnt_o (arb_gnt)
  );

  assign pick = slot_en_i ? arb_gnt : '0;

  for (genvar k = 0; k < N; k++) begin : g_cnt
    addr_counter #(.AW(AW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .zero_i     ((k == CLR) ? clear_start_i : 1'b0),
      .load_i     (load_i[k]),
      .load_val_i (load_addr_i[k*AW +: AW]),
      .adv_i      (pick[k]),
      .cur_o      (cur[k])
    );
  end

  always_comb begin
    sel_addr = '0;
    sel_wr   = 1'b0;
    for (int k = 0; k < N; k++) begin
      sel_addr = sel_addr | (cur[k] & {AW{pick[k]}});
      sel_wr   = sel_wr | (wr_eff[k] & pick[k]);
    end
  end

  assign last_hit = clearing_q & pick[CLR] & (&cur[CLR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clearing_q <= 1'b0;
      done_q     <= 1'b0;
    end else if (clear_start_i) begin
      clearing_q <= 1'b1;
      done_q     <= 1'b0;
    end else if (last_hit) begin
      clearing_q <= 1'b0;
      done_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      addr_q <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      zero_q <= 1'b0;
    end else if (slot_en_i) begin
      gnt_q  <= pick;
      act_q  <= |pick;
      wr_q   <= sel_wr;
      zero_q <= pick[CLR] & clearing_q;
      if (|pick) addr_q <= sel_addr;
    end
  end

  assign gnt_o        = gnt_q;
  assign addr_o       = addr_q;
  assign ce_no        = ~act_q;
  assign we_no        = ~(act_q & wr_q);
  assign oe_no        = ~(act_q & ~wr_q);
  assign zero_fill_o  = zero_q;
  assign clear_done_o = done_q;
endmodule

// File: rtl/mem_addr_arb_chk.sv
module mem_addr_arb_chk #(
  parameter int unsigned AW = 15,
  parameter int unsigned N  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          slot_en_i,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  gnt_o,
  input logic [AW-1:0] addr_o,
  input logic          ce_no,
  input logic          we_no,
  input logic          oe_no,
  input logic          zero_fill_o,
  input logic          clear_done_o
);
  a_r4_onehot_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r5_no_we_oe_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));

  a_r5_ce_tracks_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) == !ce_no));

  a_r2_hold_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(slot_en_i) |-> ($stable(addr_o) && $stable(gnt_o) && $stable(ce_no)));

  for (genvar i = 0; i < N; i++) begin : g_prio
    localparam logic [N-1:0] HIGHER = N'((1 << i) - 1);
    a_r3_no_higher_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(slot_en_i) && gnt_o[i]) |-> (($past(req_i) & HIGHER) == '0));
    if (i < N - 1) begin : g_req
      a_r4_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(slot_en_i) && gnt_o[i]) |-> $past(req_i[i]));
    end
  end

  a_r9_done_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clear_done_o) |-> ((&addr_o) && !we_no && zero_fill_o));

  a_r9_zero_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_fill_o |-> (!we_no && gnt_o[N-1]));
endmodule

bind mem_addr_arb mem_addr_arb_chk #(.AW(AW), .N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_en_i    (slot_en_i),
  .req_i        (req_i),
  .gnt_o        (gnt_o),
  .addr_o       (addr_o),
  .ce_no        (ce_no),
  .we_no        (we_no),
  .oe_no        (oe_no),
  .zero_fill_o  (zero_fill_o),
  .clear_done_o (clear_done_o)
);

// File: tb/mem_addr_arb_test.sv
`timescale 1ns/1ps
module mem_addr_arb_test;
  localparam int AW = 15;
  localparam int N  = 5;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            slot_en = 1'b0;
  logic [N-1:0]    req = '0, wr = '0, ld = '0;
  logic [N*AW-1:0] ld_val = '0;
  logic            clr_start = 1'b0;
  logic [N-1:0]    gnt;
  logic [AW-1:0]   addr;
  logic            ce_n, we_n, oe_n, zfill, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mem_addr_arb uut (
    .clk_i (clk), .rst_ni (rst_ni), .slot_en_i (slot_en),
    .req_i (req), .wr_i (wr), .load_i (ld), .load_addr_i (ld_val),
    .clear_start_i (clr_start), .gnt_o (gnt), .addr_o (addr),
    .ce_no (ce_n), .we_no (we_n), .oe_no (oe_n),
    .zero_fill_o (zfill), .clear_done_o (done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // inputs already set on a falling edge; open one slot, sample at next falling edge
  task automatic do_slot();
    slot_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    slot_en = 1'b0;
    req = '0;
    wr = '0;
    ld = '0;
  endtask

  task automatic t_reset();
    chk("R1 gnt", gnt, 0);
    chk("R1 addr", addr, 0);
    chk("R1 strobes", {ce_n, we_n, oe_n}, 3'b111);
    chk("R1 flags", {zfill, done}, 2'b00);
  endtask

  task automatic t_priority();
    // preset counters at a non-slot edge
    ld = '1;
    ld_val[0*AW +: AW] = 15'd100;
    ld_val[1*AW +: AW] = 15'd2000;
    ld_val[2*AW +: AW] = 15'd3000;
    ld_val[3*AW +: AW] = 15'd4000;
    ld_val[4*AW +: AW] = 15'd5000;
    @(posedge clk); @(negedge clk);
    ld = '0;
    chk("R2 no slot no grant", gnt, 0);
    req = 5'b11111; do_slot();
    chk("R3 conv wins", gnt, 5'b00001);
    chk("R3 conv addr", addr, 100);
    chk("R5 read strobes", {ce_n, we_n, oe_n}, 3'b010);
    req = 5'b11110; do_slot();
    chk("R3 stream next", gnt, 5'b00010);
    chk("R6 stream held while losing", addr, 2000);
    req = 5'b11100; do_slot();
    chk("R3 ecc next", gnt, 5'b00100);
    chk("R3 ecc addr", addr, 3000);
    req = 5'b11000; do_slot();
    chk("R3 subcode next", gnt, 5'b01000);
    chk("R3 subcode addr", addr, 4000);
    req = 5'b10000; do_slot();
    chk("R3 refresh last", gnt, 5'b10000);
    chk("R3 refresh addr", addr, 5000);
    req = 5'b00001; do_slot();
    chk("R6 conv post-increment", addr, 101);
  endtask

  task automatic t_idle_hold();
    req = 5'b00010; wr = 5'b00010; do_slot();
    chk("R6 stream advanced", addr, 2001);
    chk("R5 write strobes", {ce_n, we_n, oe_n}, 3'b001);
    @(posedge clk); @(negedge clk);
    chk("R2 grant held", gnt, 5'b00010);
    chk("R2 addr held", addr, 2001);
    chk("R2 strobes held", {ce_n, we_n, oe_n}, 3'b001);
    do_slot();
    chk("R4 idle no grant", gnt, 0);
    chk("R5 idle strobes", {ce_n, we_n, oe_n}, 3'b111);
  endtask

  task automatic t_load_wrap();
    ld = 5'b00100;
    ld_val[2*AW +: AW] = 15'd32767;
    req = 5'b00100;
    do_slot();
    chk("R8 load same slot", addr, 32767);
    req = 5'b00100; do_slot();
    chk("R7 wrap to zero", addr, 0);
    req = 5'b01000; wr = 5'b01000; do_slot();
    chk("R6 subcode advanced", addr, 4001);
    chk("R5 subcode write", {we_n, oe_n}, 2'b01);
  endtask

  task automatic t_clear();
    int bad_addr = 0, bad_flag = 0, bad_done = 0;
    clr_start = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_start = 1'b0;
    chk("R9 done low after start", done, 0);
    req = 5'b00001; do_slot();
    chk("R10 conv beats clear", gnt, 5'b00001);
    chk("R10 no zero fill", zfill, 0);
    slot_en = 1'b1;
    for (int i = 0; i < 32768; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 32767) slot_en = 1'b0;
      if (addr != AW'(i) || gnt != 5'b10000) bad_addr++;
      if (!zfill || we_n || !oe_n || ce_n) bad_flag++;
      if (done != (i == 32767)) bad_done++;
    end
    chk("R10 clear addresses in order from 0", bad_addr, 0);
    chk("R9 zero-fill write strobes", bad_flag, 0);
    chk("R9 done only at last address", bad_done, 0);
    do_slot();
    chk("R9 clear stops", gnt, 0);
    chk("R9 done sticky", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_idle_hold();
    t_load_wrap();
    t_clear();
    finish_run();
  end
endmodule